// File: doc/BRIEF.md
# Multiplexed-Bus Machine-Cycle Timer

This block produces the external bus timing of a small processor whose low address byte and data share one multiplexed bus, while the upper address byte has dedicated lines. Every machine cycle is split into one-clock states. T1 carries the address and the latch strobe. T2 and T3 carry the read or write strobe. An opcode fetch adds a bus-idle decode state after the read data is taken.

A built-in instruction sequencer drives the cycle types. It fetches an opcode from the program counter. When that opcode is the output instruction, it reads the next byte as a port number and then writes the accumulator input to that port with an I/O write cycle. Any other opcode is followed directly by the next opcode fetch. Read data is captured into a register that is visible at the `rd_data` port. The block drives the shared bus through a separate output and enable pair, so an external tri-state buffer can be placed on it.

Top module: `mcyc_bus_timer`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `io_sel` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `rd_data` is 0. The first machine cycle after release is an opcode fetch from address 0, and its T1 appears one clock after release.
- R2: `ale` is high for exactly the T1 state of every machine cycle. During T1, `ad_oe` is 1, `ad_out` carries the low address byte and `addr_hi` carries the high byte.
- R3: `io_sel` is 1 for I/O cycles and 0 for memory cycles. `io_sel` and `addr_hi` stay unchanged from T1 to the last state of the cycle.
- R4: In a read cycle, `rd_n` is 0 in T2 and T3 only, and `ad_oe` is 0 from T2 to the end of the cycle.
- R5: Read data is taken from `ad_in` at the clock edge that ends T3, not the edge that ends T2. It appears on `rd_data` from the next state onward.
- R6: An opcode fetch lasts FETCH_STATES states (default 4). Its states after T3 are idle, with `rd_n` high and `ad_oe` low. A memory read and an I/O write each last 3 states.
- R7: In a write cycle, `wr_n` is 0 in T2 and T3 only, and during those states `ad_oe` is 1 with `ad_out` equal to `acc`.
- R8: In an I/O cycle, the 8-bit port number appears on both `addr_hi` and the low address byte in T1.
- R9: A fetched opcode equal to OUT_OPCODE (default 8'hD3) is followed by a memory read at the next address and then an I/O write to the byte read, after which fetching resumes two addresses past the opcode. Any other opcode is followed by a fetch at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | DATA_W | Value read from the multiplexed bus |
| acc | input | DATA_W | Accumulator value written by the output instruction |
| ad_out | output | DATA_W | Value driven onto the multiplexed bus |
| ad_oe | output | 1 | Multiplexed bus drive enable |
| addr_hi | output | ADDR_W-DATA_W | High address lines |
| ale | output | 1 | Address latch strobe, high in T1 |
| io_sel | output | 1 | 1 selects I/O space, 0 selects memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rd_data | output | DATA_W | Last captured read data |

## Verification
The assertions assume that `acc` stays steady during a write cycle. They also assume that `ad_in` is valid by the end of T3 of a read. The stimulus meets this with a memory model that latches the address while `ale` is high. That model returns the wrong byte 8'hEE in the first read state and the programmed byte only in the second. It never changes `acc`. Reset is asserted once in the middle of an I/O write to confirm that it takes effect immediately, without waiting for the cycle to end.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   typedef enum logic [2:0] {
      CYC_FETCH  = 3'd0,
      CYC_MEM_RD = 3'd1,
      CYC_MEM_WR = 3'd2,
      CYC_IO_RD  = 3'd3,
      CYC_IO_WR  = 3'd4
   } cyc_e;

   function automatic logic cyc_is_io(cyc_e c);
      return (c == CYC_IO_RD) || (c == CYC_IO_WR);
   endfunction

   function automatic logic cyc_is_wr(cyc_e c);
      return (c == CYC_MEM_WR) || (c == CYC_IO_WR);
   endfunction

endpackage

// File: rtl/mcyc_tstate.sv
module mcyc_tstate
   import mcyc_pkg::*;
#(
   parameter int FETCH_STATES = 4,
   parameter int RW_STATES    = 3,
   localparam int TS_W        = $clog2(FETCH_STATES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cyc_e            cyc,
   output logic [TS_W-1:0] ts,
   output logic            started,
   output logic            last
);

   logic [TS_W-1:0] ts_final;

   always_comb begin
      ts_final = (cyc == CYC_FETCH) ? TS_W'(FETCH_STATES - 1) : TS_W'(RW_STATES - 1);
      last     = started && (ts == ts_final);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         ts      <= '0;
      end else if (!started) begin
         started <= 1'b1;
      end else if (last) begin
         ts <= '0;
      end else begin
         ts <= ts + 1'b1;
      end
   end

   // R6: a non-fetch cycle never reaches a state beyond its third
   p_rw_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (started && cyc != CYC_FETCH) |-> (ts <= TS_W'(RW_STATES - 1)));

   // R6: a finished cycle restarts at T1
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (ts == '0));

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] OUT_OPCODE = 8'hD3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] ad_in,
   output cyc_e              cyc,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] port,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc     <= CYC_FETCH;
         pc      <= '0;
         port    <= '0;
         rd_data <= '0;
      end else begin
         if (cap_en) rd_data <= ad_in;
         if (last) begin
            unique case (cyc)
               CYC_FETCH: begin
                  pc  <= pc + 1'b1;
                  cyc <= (rd_data == OUT_OPCODE) ? CYC_MEM_RD : CYC_FETCH;
               end
               CYC_MEM_RD: begin
                  pc   <= pc + 1'b1;
                  port <= ad_in;
                  cyc  <= CYC_IO_WR;
               end
               default: cyc <= CYC_FETCH;
            endcase
         end
      end
   end

   // R9: every completed fetch advances the program counter by one
   p_fetch_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (last && cyc == CYC_FETCH) |=> (pc == $past(pc) + 1'b1));

   // R9: the byte read after the opcode becomes the port of the following write
   p_port_from_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (last && cyc == CYC_MEM_RD) |=> (cyc == CYC_IO_WR && port == $past(ad_in)));

endmodule

// File: rtl/mcyc_pins.sv
module mcyc_pins
   import mcyc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int TS_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     started,
   input  logic [TS_W-1:0]          ts,
   input  cyc_e                     cyc,
   input  logic [ADDR_W-1:0]        pc,
   input  logic [DATA_W-1:0]        port,
   input  logic [DATA_W-1:0]        acc,
   output logic                     ale,
   output logic                     io_sel,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic [ADDR_W-DATA_W-1:0] addr_hi
);

   logic [ADDR_W-1:0] addr;
   logic              in_t1, strobe_win, is_wr;

   always_comb begin
      addr       = cyc_is_io(cyc) ? {port, port} : pc;
      is_wr      = cyc_is_wr(cyc);
      in_t1      = started && (ts == '0);
      strobe_win = started && (ts == TS_W'(1) || ts == TS_W'(2));
      ale        = in_t1;
      io_sel     = started && cyc_is_io(cyc);
      rd_n       = !(strobe_win && !is_wr);
      wr_n       = !(strobe_win && is_wr);
      ad_oe      = in_t1 || (strobe_win && is_wr);
      ad_out     = in_t1 ? addr[DATA_W-1:0] : acc;
      addr_hi    = addr[ADDR_W-1:DATA_W];
   end

   // R2: the latch strobe lasts exactly one state
   p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R3: cycle attributes hold between strobes
   p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |-> ($stable(addr_hi) && $stable(io_sel)));

   // R4: the bus is released while reading
   p_rd_bus_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R5: the read strobe spans two states
   p_rd_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |=> !rd_n);

   // R7: write strobe spans two states with the bus driven
   p_wr_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |=> (!wr_n && ad_oe));

   // R4: read and write strobes never overlap
   p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

endmodule

// File: rtl/mcyc_bus_timer.sv
module mcyc_bus_timer
   import mcyc_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter int                DATA_W       = 8,
   parameter int                FETCH_STATES = 4,
   parameter logic [DATA_W-1:0] OUT_OPCODE   = 8'hD3,
   localparam int               RW_STATES    = 3,
   localparam int               TS_W         = $clog2(FETCH_STATES),
   localparam int               HI_W         = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   addr_hi,
   output logic              ale,
   output logic              io_sel,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W so a port fills both address bytes");
      end
      if (FETCH_STATES < RW_STATES + 1 || FETCH_STATES > RW_STATES + 2) begin : g_bad_fetch
         $error("FETCH_STATES must allow one or two decode states");
      end
   endgenerate

   cyc_e              cyc;
   logic [TS_W-1:0]   ts;
   logic              started, last, cap_en;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] port;

   assign cap_en = started && !cyc_is_wr(cyc) && (ts == TS_W'(2));

   mcyc_tstate #(.FETCH_STATES(FETCH_STATES), .RW_STATES(RW_STATES)) u_tstate (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .ts(ts), .started(started), .last(last)
   );

   mcyc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_OPCODE(OUT_OPCODE)) u_seq (
      .clk(clk), .rst_n(rst_n), .last(last), .cap_en(cap_en), .ad_in(ad_in),
      .cyc(cyc), .pc(pc), .port(port), .rd_data(rd_data)
   );

   mcyc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .started(started), .ts(ts), .cyc(cyc), .pc(pc),
      .port(port), .acc(acc), .ale(ale), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n),
      .ad_oe(ad_oe), .ad_out(ad_out), .addr_hi(addr_hi)
   );

   // R1: a fresh start always begins with a T1 strobe
   p_start_ale_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started) |-> ale);

   // R5: captured data changes only at the end of a read strobe window
   p_capture_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $past(!rd_n));

endmodule

// File: tb/mcyc_bus_timer_test.sv
module mcyc_bus_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ad_in, acc, ad_out, addr_hi, rd_data;
   logic       ad_oe, ale, io_sel, rd_n, wr_n;
   logic [15:0] lat_addr = 16'h0;
   logic        rd_seen = 1'b0;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   mcyc_bus_timer uut (
      .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .acc(acc), .ad_out(ad_out),
      .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale), .io_sel(io_sel),
      .rd_n(rd_n), .wr_n(wr_n), .rd_data(rd_data)
   );

   function automatic logic [7:0] mem(logic [15:0] a);
      case (a)
         16'h0000: return 8'hD3;
         16'h0001: return 8'h5A;
         16'h0002: return 8'h00;
         16'h0003: return 8'hD3;
         16'h0004: return 8'hFF;
         default:  return 8'h00;
      endcase
   endfunction

   // memory model: wrong byte in the first read state, real byte in the second
   always @(posedge clk) begin
      if (ale) lat_addr <= {addr_hi, ad_out};
      rd_seen <= !rd_n;
   end
   assign ad_in = (!rd_n && rd_seen) ? mem(lat_addr) : 8'hEE;

   // {3'b0, ale, io_sel, rd_n, wr_n, ad_oe}, addr_hi, ad_out (when driven), rd_data
   localparam logic [31:0] VEC [24] = '{
      32'h17_00_00_00, 32'h02_00_00_00, 32'h02_00_00_00, 32'h06_00_00_D3,
      32'h17_00_01_D3, 32'h02_00_00_D3, 32'h02_00_00_D3,
      32'h1F_5A_5A_5A, 32'h0D_5A_3C_5A, 32'h0D_5A_3C_5A,
      32'h17_00_02_5A, 32'h02_00_00_5A, 32'h02_00_00_5A, 32'h06_00_00_00,
      32'h17_00_03_00, 32'h02_00_00_00, 32'h02_00_00_00, 32'h06_00_00_D3,
      32'h17_00_04_D3, 32'h02_00_00_D3, 32'h02_00_00_D3,
      32'h1F_FF_FF_FF, 32'h0D_FF_3C_FF, 32'h0D_FF_3C_FF
   };

   function automatic logic [31:0] observe();
      return {3'b000, ale, io_sel, rd_n, wr_n, ad_oe, addr_hi,
              (ad_oe ? ad_out : 8'h00), rd_data};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic restart();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: all strobes idle and capture register cleared while in reset
      check("R1 reset idle", observe(), 32'h06_00_00_00);
      rst_n = 1'b1;
   endtask

   initial begin
      acc = 8'h3C;
      restart();
      // R2 R3 R4 R5 R6 R7 R8 R9: full output-instruction sequence and a plain fetch
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 state %0d", i), observe(), VEC[i]);
      end

      // R1: reset taken in the middle of an I/O write
      restart();
      for (int i = 0; i < 9; i++) @(negedge clk);
      check("R7 write strobe before reset", {31'b0, wr_n}, 32'h0);
      #1 rst_n = 1'b0;
      #1 check("R1 reset mid-write", observe(), 32'h06_00_00_00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first fetch at zero", observe(), 32'h17_00_00_00);
      @(negedge clk);
      check("R4 read strobe after restart", observe(), 32'h02_00_00_00);
      @(negedge clk);
      @(negedge clk);
      // R5: wrong byte presented in T2 must not be captured
      check("R5 capture at end of T3", {24'b0, rd_data}, 32'h0000_00D3);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule